// File: doc/BRIEF.md
# Supply Lockout and Startup Controller

This block decides when a power controller may run. It watches a digitized supply-voltage code, one sample per clock, and drives a global run flag, a force-low flag for the output, soft-start and current-sense pins, and the enable of a high-voltage startup current source. After reset it always sits in lockout with the pins forced low. It enters run once the supply code has reached the turn-on level. It falls back to lockout once the code has dropped below the turn-off level.

Two variants share the logic and are picked by a static select. The variant with a startup source turns on at a high level and keeps the source enabled through lockout. While running, it enables the source again when the supply sags below an intermediate level and the outputs are idle, so the source can carry the bias current between bursts. The variant without a source turns on at a lower level and never enables the source.

Every threshold decision is filtered: a comparison must hold on two consecutive samples before it acts. A single noisy code therefore changes nothing.

Top module: `uvlo_startup_ctrl`

## Requirements
- R1: While reset is low, and right after it is released, the block is in lockout whatever the supply code: run_o=0, force_low_o=1, startup_on_o equals variant_i.
- R2: With variant_i=1 (source fitted), run_o rises after two consecutive samples with supply_i >= 130. A value of 130 counts as reached and 129 does not.
- R3: With variant_i=0 (no source), run_o rises after two consecutive samples with supply_i >= 100.
- R4: A condition seen on only one sample, followed by a sample without it, changes neither run_o nor startup_on_o. The output changes at the clock edge of the second consecutive qualifying sample.
- R5: In run, two consecutive samples with supply_i < 80 return the block to lockout. A value of 80 keeps it running.
- R6: force_low_o is 1 exactly when run_o is 0.
- R7: With variant_i=1, startup_on_o is 1 throughout lockout and drops to 0 on entry to run.
- R8: In run with variant_i=1, two consecutive samples with supply_i < 100 and switching_i=0 set startup_on_o to 1 while run_o stays 1. A value of 100 does not trigger this.
- R9: While switching_i=1, a supply code in [80,100) does not enable the source. Below 80 the lockout of R5 and R7 turns it on.
- R10: A source that was re-enabled in run turns off again after two consecutive samples with supply_i >= 130. A value of 129 leaves it on.
- R11: With variant_i=0, startup_on_o is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the supply code is sampled on each rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_i | input | VW (8) | Digitized supply voltage, 0.1 V per LSB |
| switching_i | input | 1 | High while the power outputs are switching |
| variant_i | input | 1 | 1 = startup source fitted (high turn-on level), 0 = no source |
| run_o | output | 1 | Block is out of lockout |
| startup_on_o | output | 1 | Enable for the high-voltage startup source |
| force_low_o | output | 1 | Forces the soft-start, current-sense and output pins low |

## Verification
The assertions assume that supply_i and switching_i are synchronous to clk_i. They also assume that variant_i is a strap: it changes only while reset is held, which lets the checker compare against a single turn-on threshold per run. The stimulus follows these rules. Inputs change only on falling edges. The variant is set only inside the reset task, and reset is held for several cycles afterwards. Each sweep point starts from a fresh reset, so no stale filter count carries over from one code to the next.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;
  typedef enum logic [0:0] {ST_LOCK = 1'b0, ST_RUN = 1'b1} uvlo_state_e;
endpackage

// File: rtl/uvlo_filt.sv
// Passes a condition only once it has held for DEPTH consecutive samples.
module uvlo_filt #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!cond_i)      cnt_q <= '0;
    else if (cnt_q < LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = cond_i && (cnt_q >= LAST);
endmodule

// File: rtl/uvlo_fsm.sv
module uvlo_fsm
  import uvlo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic variant_i,
  input  logic on_hit_i,
  input  logic off_hit_i,
  input  logic sag_hit_i,
  output logic run_o,
  output logic startup_on_o
);
  uvlo_state_e state_q;
  logic        rearm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCK;
      rearm_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_LOCK: begin
          rearm_q <= 1'b0;
          if (on_hit_i) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (off_hit_i) begin
            state_q <= ST_LOCK;
            rearm_q <= 1'b0;
          end else if (sag_hit_i && variant_i) begin
            rearm_q <= 1'b1;
          end else if (on_hit_i) begin
            rearm_q <= 1'b0;
          end
        end
        default: state_q <= ST_LOCK;
      endcase
    end
  end

  assign run_o        = (state_q == ST_RUN);
  assign startup_on_o = variant_i && ((state_q == ST_LOCK) || rearm_q);
endmodule

// File: rtl/uvlo_startup_ctrl.sv
module uvlo_startup_ctrl #(
  parameter int unsigned VW          = 8,
  parameter int unsigned TH_ON_SRC   = 130,
  parameter int unsigned TH_ON_NOSRC = 100,
  parameter int unsigned TH_REARM    = 100,
  parameter int unsigned TH_OFF      = 80,
  parameter int unsigned DEB_DEPTH   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] supply_i,
  input  logic          switching_i,
  input  logic          variant_i,
  output logic          run_o,
  output logic          startup_on_o,
  output logic          force_low_o
);
  localparam int unsigned NCOND = 3;
  localparam int unsigned C_ON  = 0;
  localparam int unsigned C_OFF = 1;
  localparam int unsigned C_SAG = 2;

  logic [VW-1:0]    on_thr;
  logic [NCOND-1:0] cond;
  logic [NCOND-1:0] hit;

  assign on_thr      = variant_i ? VW'(TH_ON_SRC) : VW'(TH_ON_NOSRC);
  assign cond[C_ON]  = supply_i >= on_thr;
  assign cond[C_OFF] = supply_i < VW'(TH_OFF);
  assign cond[C_SAG] = (supply_i < VW'(TH_REARM)) && !switching_i;

  for (genvar g = 0; g < NCOND; g++) begin : g_filt
    uvlo_filt #(.DEPTH(DEB_DEPTH)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cond_i (cond[g]),
      .hit_o  (hit[g])
    );
  end

  uvlo_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .variant_i    (variant_i),
    .on_hit_i     (hit[C_ON]),
    .off_hit_i    (hit[C_OFF]),
    .sag_hit_i    (hit[C_SAG]),
    .run_o        (run_o),
    .startup_on_o (startup_on_o)
  );

  assign force_low_o = !run_o;
endmodule

// File: rtl/uvlo_startup_ctrl_chk.sv
module uvlo_startup_ctrl_chk #(
  parameter int unsigned VW          = 8,
  parameter int unsigned TH_ON_SRC   = 130,
  parameter int unsigned TH_ON_NOSRC = 100,
  parameter int unsigned TH_REARM    = 100,
  parameter int unsigned TH_OFF      = 80
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [VW-1:0] supply_i,
  input logic          switching_i,
  input logic          variant_i,
  input logic          run_o,
  input logic          startup_on_o,
  input logic          force_low_o
);
  logic [VW-1:0] thr;
  assign thr = variant_i ? VW'(TH_ON_SRC) : VW'(TH_ON_NOSRC);

  // R2 / R3 / R4: entry to run needs two qualifying samples
  a_r4_on_two_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> ($past(supply_i, 1) >= thr) && ($past(supply_i, 2) >= thr));

  a_r5_off_two_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> ($past(supply_i, 1) < VW'(TH_OFF)) && ($past(supply_i, 2) < VW'(TH_OFF)));

  a_r7_source_off_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> !startup_on_o);

  a_r8_rearm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(startup_on_o) && run_o) |-> ($past(supply_i) < VW'(TH_REARM)) && !$past(switching_i));

  a_r9_no_rearm_switching: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(switching_i)) |-> !$rose(startup_on_o));

  a_r11_no_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !variant_i |-> !startup_on_o);

  a_r6_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_low_o != run_o);
endmodule

bind uvlo_startup_ctrl uvlo_startup_ctrl_chk #(
  .VW(VW), .TH_ON_SRC(TH_ON_SRC), .TH_ON_NOSRC(TH_ON_NOSRC),
  .TH_REARM(TH_REARM), .TH_OFF(TH_OFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .supply_i(supply_i), .switching_i(switching_i),
  .variant_i(variant_i), .run_o(run_o), .startup_on_o(startup_on_o),
  .force_low_o(force_low_o)
);

// File: tb/uvlo_startup_ctrl_bench.sv
module uvlo_startup_ctrl_bench;
  localparam int CLK_P    = 10;
  localparam int ON_SRC   = 130;
  localparam int ON_NOSRC = 100;
  localparam int REARM    = 100;
  localparam int OFF      = 80;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] supply = 8'd0;
  logic       sw = 1'b0;
  logic       variant = 1'b0;
  logic       run, src, frc;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_P / 2) clk = ~clk;

  uvlo_startup_ctrl u_uvlo_startup_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .supply_i(supply), .switching_i(sw),
    .variant_i(variant), .run_o(run), .startup_on_o(src), .force_low_o(frc)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b supply=%0d sw=%0b var=%0b t=%0t",
               req, act, exp, supply, sw, variant, $time);
    end
  endtask

  task automatic do_reset(input logic v, input int code);
    @(negedge clk);
    rst_ni  = 1'b0;
    variant = v;
    supply  = 8'(code);
    sw      = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 run in reset", run, 1'b0);
    rst_ni = 1'b1;
  endtask

  task automatic step(input int code, input logic s);
    supply = 8'(code);
    sw     = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 R2 R3 R4 R7 R11: turn-on sweep, code held through reset
    for (int v = 0; v < 2; v++) begin
      for (int c = 0; c < 256; c++) begin
        automatic int  thr = v ? ON_SRC : ON_NOSRC;
        automatic logic up = (c >= thr);
        do_reset(v[0], c);
        chk("R1 run", run, 1'b0);
        chk("R1 force", frc, 1'b1);
        chk("R1 src", src, v[0]);
        step(c, 1'b0);
        chk("R4 one sample", run, 1'b0);
        step(c, 1'b0);
        chk(v ? "R2 turn-on" : "R3 turn-on", run, up);
        chk("R6 force", frc, !up);
        chk(v ? "R7 src" : "R11 src", src, v[0] && !up);
      end
    end

    // R5 R8 R9 R11: behaviour in run over all codes
    for (int v = 0; v < 2; v++) begin
      for (int s = 0; s < 2; s++) begin
        for (int c = 0; c < 256; c++) begin
          automatic logic stay = (c >= OFF);
          automatic logic exp_src = v[0] && ((c < OFF) || ((c < REARM) && !s[0]));
          do_reset(v[0], 0);
          step(200, 1'b0);
          step(200, 1'b0);
          step(c, s[0]);
          step(c, s[0]);
          chk("R5 run", run, stay);
          chk("R6 force", frc, !stay);
          chk(s ? "R9 src" : "R8 src", src, exp_src);
        end
      end
    end

    // R4: single low glitch in run
    do_reset(1'b1, 0);
    step(200, 1'b0); step(200, 1'b0);
    step(50, 1'b1);
    step(200, 1'b1); step(200, 1'b1);
    chk("R4 glitch run", run, 1'b1);
    chk("R4 glitch src", src, 1'b0);

    // R4 R9: one idle sag sample, then switching resumes
    step(90, 1'b0);
    step(90, 1'b1); step(90, 1'b1);
    chk("R4 sag once", src, 1'b0);

    // R8 R10: rearm, then clear at exactly the turn-on level
    step(90, 1'b0); step(90, 1'b0);
    chk("R8 rearm", src, 1'b1);
    chk("R8 still run", run, 1'b1);
    step(129, 1'b0); step(129, 1'b0);
    chk("R10 below on", src, 1'b1);
    step(130, 1'b0);
    chk("R10 one sample", src, 1'b1);
    step(130, 1'b0);
    chk("R10 clear", src, 1'b0);
    chk("R10 run", run, 1'b1);

    finish_run();
  end
endmodule